// File: doc/BRIEF.md
# Cluster Shared Memory with Fixed-Priority Access

This block is the shared data store of a processor cluster. Nine requester ports compete for one word-wide memory: eight core ports (index 0 to 7) and one receiver port (index 8). The storage holds 8K words of 32 bits. It is divided into four banks, and the two low-order address bits select the bank, so neighbouring words sit in different banks. In every cycle a hardwired priority chain picks one requester. The lowest index wins and the receiver port comes last. The winning access is registered and steered to its bank. The following cycle returns an acknowledge pulse, with the read data on the shared read bus.

A requester raises its request with the write enable, the word address and the write data, and holds all of them steady until it sees its acknowledge. It may drop the request in the acknowledge cycle or in the cycle after it. Without competition the acknowledge comes two clock edges after the request is first sampled. Grants are pipelined: a new requester can be granted in every cycle, so a queue of waiting requesters drains at one access per cycle in priority order.

Top module: `shmem_cluster`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no request pending, every acknowledge bit is 0.
- R2: Among the requesters competing in a cycle, the one with the lowest port index is granted, and the receiver port (index 8) has the lowest priority of all.
- R3: A request with no competition, raised before clock edge N, sees its acknowledge high in the cycle that follows edge N+1 (two cycles of latency). This holds for reads and for writes on every port.
- R4: A read returns the word most recently written to the same address. The read data bus carries it in the same cycle as the acknowledge.
- R5: Bits [1:0] of the 13-bit word address select the bank and bits [12:2] select the row inside it. All 8192 addresses, including 0 and 8191, hold independent words.
- R6: Only one requester is granted per cycle. A waiting requester is served after every higher-priority request present at that time. A higher-priority request that arrives later overtakes a lower-priority one that is still waiting. With k simultaneous requests the acknowledges come in k consecutive cycles.
- R7: At most one acknowledge bit is high in any cycle.
- R8: An acknowledge goes only to a port that held its request. A request that is still held during its own acknowledge cycle is served exactly once.
- R9: When a write and reads of the same address are granted in the same cycle window, they take effect in grant order. A read granted before the write returns the old word, and a read granted after it returns the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 9 | Access request, one bit per port |
| we_i | input | 9 | Write enable per port (1 = write, 0 = read) |
| addr_i | input | 117 | Word addresses, port p in bits [13p+12:13p] |
| wdata_i | input | 288 | Write data, port p in bits [32p+31:32p] |
| ack_o | output | 9 | One-cycle acknowledge per port |
| rdata_o | output | 32 | Read data, valid with the acknowledge of a read |

## Verification
Arbitration and the memory pipeline meet when a write and reads of the same word are granted in consecutive cycles. That case comes about when requesters on either side of the writer in priority order raise their requests in the same cycle. The bench provokes it by having a higher-priority reader, a writer and a lower-priority reader all target one address at once. It then judges whether each returned word matches its place in the grant order, and whether each acknowledge falls in the cycle its priority rank predicts. A second overlap is a late high-priority arrival that overtakes a waiting low-priority request. The bench checks it by measuring each port's acknowledge cycle against the expected order.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  localparam int unsigned SHM_REQS   = 9;
  localparam int unsigned SHM_DATA_W = 32;
  localparam int unsigned SHM_ADDR_W = 13;
  localparam int unsigned SHM_BANKS  = 4;

  // bank chosen by low-order address bits (nb is a power of two)
  function automatic int unsigned bank_of(int unsigned word_addr, int unsigned nb);
    return word_addr % nb;
  endfunction

  // row inside the bank from the remaining upper bits
  function automatic int unsigned row_of(int unsigned word_addr, int unsigned nb);
    return word_addr / nb;
  endfunction
endpackage

// File: rtl/shmem_prio_arb.sv
module shmem_prio_arb #(
  parameter int unsigned NREQ = 9,
  localparam int unsigned IDX_W = $clog2(NREQ)
) (
  input  logic [NREQ-1:0]  req,
  input  logic [NREQ-1:0]  busy,
  output logic [NREQ-1:0]  grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_valid
);
  logic [NREQ-1:0] elig;

  always_comb begin
    elig        = req & ~busy;
    grant       = '0;
    grant_idx   = '0;
    grant_valid = 1'b0;
    // walk from lowest priority upward; last hit (lowest index) wins
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant       = '0;
        grant[i]    = 1'b1;
        grant_idx   = IDX_W'(i);
        grant_valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/shmem_bank.sv
module shmem_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROW_W  = 11,
  localparam int unsigned DEPTH = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/shmem_cluster.sv
module shmem_cluster
  import shmem_pkg::*;
#(
  parameter int unsigned NREQ      = SHM_REQS,
  parameter int unsigned DATA_W    = SHM_DATA_W,
  parameter int unsigned ADDR_W    = SHM_ADDR_W,
  parameter int unsigned NUM_BANKS = SHM_BANKS,
  localparam int unsigned IDX_W    = $clog2(NREQ),
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned ROW_W    = ADDR_W - BANK_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_i,
  input  logic [NREQ-1:0]          we_i,
  input  logic [NREQ*ADDR_W-1:0]   addr_i,
  input  logic [NREQ*DATA_W-1:0]   wdata_i,
  output logic [NREQ-1:0]          ack_o,
  output logic [DATA_W-1:0]        rdata_o
);
  // per-port views of the flat buses
  logic [ADDR_W-1:0] addr_a  [NREQ];
  logic [DATA_W-1:0] wdata_a [NREQ];

  for (genvar p = 0; p < NREQ; p++) begin : g_unpack
    assign addr_a[p]  = addr_i[p*ADDR_W +: ADDR_W];
    assign wdata_a[p] = wdata_i[p*DATA_W +: DATA_W];
  end

  // named events for the checker
  logic [NREQ-1:0]  grant_vec;
  logic [IDX_W-1:0] grant_idx;
  logic             grant_valid;
  logic [NREQ-1:0]  busy_vec;
  logic [NREQ-1:0]  s1_hot;

  // stage 1: registered winner
  logic              s1_valid;
  logic [IDX_W-1:0]  s1_idx;
  logic              s1_we;
  logic [BANK_W-1:0] s1_bank;
  logic [ROW_W-1:0]  s1_row;
  logic [DATA_W-1:0] s1_wdata;

  // stage 2: return path
  logic [BANK_W-1:0] ack_bank;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_en;

  logic [ADDR_W-1:0] sel_addr;
  logic [BANK_W-1:0] sel_bank;
  logic [ROW_W-1:0]  sel_row;

  assign s1_hot   = s1_valid ? (NREQ'(1) << s1_idx) : '0;
  // a port in flight or in its acknowledge cycle is not re-granted
  assign busy_vec = s1_hot | ack_o;

  shmem_prio_arb #(.NREQ(NREQ)) u_arb (
    .req         (req_i),
    .busy        (busy_vec),
    .grant       (grant_vec),
    .grant_idx   (grant_idx),
    .grant_valid (grant_valid)
  );

  assign sel_addr = addr_a[grant_idx];
  assign sel_bank = BANK_W'(bank_of(32'(sel_addr), NUM_BANKS));
  assign sel_row  = ROW_W'(row_of(32'(sel_addr), NUM_BANKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= grant_valid;
  end

  always_ff @(posedge clk) begin
    if (grant_valid) begin
      s1_idx   <= grant_idx;
      s1_we    <= we_i[grant_idx];
      s1_bank  <= sel_bank;
      s1_row   <= sel_row;
      s1_wdata <= wdata_a[grant_idx];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b] = s1_valid && (s1_bank == BANK_W'(b));
    shmem_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (s1_we),
      .row   (s1_row),
      .wdata (s1_wdata),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_o <= '0;
    else        ack_o <= s1_hot;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) ack_bank <= s1_bank;
  end

  assign rdata_o = bank_rd[ack_bank];
endmodule

// File: rtl/shmem_cluster_chk.sv
module shmem_cluster_chk #(
  parameter int unsigned NREQ = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_i,
  input logic [NREQ-1:0] ack_o,
  input logic [NREQ-1:0] grant_vec,
  input logic [NREQ-1:0] busy_vec
);
  // R1: reset clears acknowledges
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> ack_o == '0);

  // R2: no eligible port of lower index than the granted one
  assert_fixed_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vec != '0 |-> ((req_i & ~busy_vec) & (grant_vec - NREQ'(1))) == '0);

  // R3: a grant returns its acknowledge two edges later
  assert_two_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vec != '0 |=> ##1 ack_o == $past(grant_vec, 2));

  // R6: an eligible request never leaves a cycle idle
  assert_work_conserving_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i & ~busy_vec) != '0 |-> grant_vec != '0);

  // R7: one grant and one acknowledge at most
  assert_one_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R8: acknowledge only to a port that was requesting
  assert_ack_to_requester_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o != '0 |-> (ack_o & $past(req_i, 2)) == ack_o);
endmodule

bind shmem_cluster shmem_cluster_chk #(.NREQ(NREQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .ack_o     (ack_o),
  .grant_vec (grant_vec),
  .busy_vec  (busy_vec)
);

// File: tb/sim_shmem_cluster.sv
module sim_shmem_cluster;
  localparam int NP = 9;
  localparam int AW = 13;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] b_req = '0;
  logic [NP-1:0] b_we  = '0;
  logic [AW-1:0] b_addr [NP];
  logic [DW-1:0] b_wd   [NP];
  logic [NP*AW-1:0] addr_flat;
  logic [NP*DW-1:0] wd_flat;
  logic [NP-1:0] ack;
  logic [DW-1:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;

  int          got_cyc [NP];
  int          got_cnt [NP];
  logic [DW-1:0] got_rd [NP];
  bit          multi_ack;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      addr_flat[i*AW +: AW] = b_addr[i];
      wd_flat[i*DW +: DW]   = b_wd[i];
    end
  end

  shmem_cluster u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (b_req),
    .we_i    (b_we),
    .addr_i  (addr_flat),
    .wdata_i (wd_flat),
    .ack_o   (ack),
    .rdata_o (rdata)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // raise the ports in 'mask' at once (plus 'late' at cycle late_at), track acks
  task automatic run_batch(input logic [NP-1:0] mask, input logic [NP-1:0] late,
                           input int late_at, input int ncyc);
    for (int i = 0; i < NP; i++) begin
      got_cyc[i] = 0; got_cnt[i] = 0; got_rd[i] = '0;
    end
    multi_ack = 1'b0;
    @(negedge clk);
    b_req = mask;
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      if (!$onehot0(ack)) multi_ack = 1'b1;
      for (int i = 0; i < NP; i++) begin
        if (ack[i]) begin
          got_cnt[i]++;
          if (got_cyc[i] == 0) got_cyc[i] = c;
          got_rd[i] = rdata;
          b_req[i] = 1'b0;
        end
      end
      if (c == late_at) b_req = b_req | late;
    end
    b_req = '0;
  endtask

  task automatic single(input int p, input bit wr, input int a, input logic [DW-1:0] d,
                        input logic [DW-1:0] exp_rd, input string tag);
    b_we[p] = wr; b_addr[p] = AW'(a); b_wd[p] = d;
    run_batch(NP'(1) << p, '0, 0, 5);
    check(got_cyc[p] == 2, {tag, " R3 latency"}, got_cyc[p], 2);
    if (!wr) check(got_rd[p] == exp_rd, {tag, " R4 read data"}, got_rd[p], exp_rd);
    b_we[p] = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(ack == '0, "R1 ack in reset", ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ack == '0, "R1 ack after release", ack, 0);
  endtask

  task automatic t_single();
    single(3, 1'b1, 5, 32'hCAFE_0005, '0, "wr p3");
    single(3, 1'b0, 5, '0, 32'hCAFE_0005, "rd p3");
    single(0, 1'b1, 5, 32'h1234_5678, '0, "wr p0 overwrite");
    single(7, 1'b0, 5, '0, 32'h1234_5678, "rd p7 R4 last write");
  endtask

  task automatic t_banks();
    int addrs [8] = '{0, 1, 2, 3, 4, 8188, 8191, 2047};
    for (int k = 0; k < 8; k++)
      single(0, 1'b1, addrs[k], 32'hB000_0000 + 32'(addrs[k]) * 3, '0, "R5 fill");
    for (int k = 0; k < 8; k++)
      single(8, 1'b0, addrs[k], '0, 32'hB000_0000 + 32'(addrs[k]) * 3, "R5 bank readback");
  endtask

  task automatic t_all_contend();
    for (int i = 0; i < NP; i++) begin b_we[i] = 1'b0; b_addr[i] = AW'(i); end
    run_batch('1, '0, 0, 14);
    for (int i = 0; i < NP; i++) begin
      check(got_cyc[i] == i + 2, "R6 R2 contention order", got_cyc[i], i + 2);
      check(got_rd[i] == 32'hB000_0000 + 32'(i) * 3 || i > 4,
            "R4 contention data", got_rd[i], 32'hB000_0000 + 32'(i) * 3);
    end
    check(got_cnt[8] == 1, "R8 receiver served once", got_cnt[8], 1);
    check(!multi_ack, "R7 single ack per cycle", multi_ack, 0);
  endtask

  task automatic t_late_overtake();
    b_addr[7] = 13'd0; b_addr[8] = 13'd1; b_addr[1] = 13'd2;
    run_batch(9'b1_1000_0000, 9'b0_0000_0010, 1, 8);
    check(got_cyc[7] == 2, "R6 first waiter", got_cyc[7], 2);
    check(got_cyc[1] == 3, "R6 R2 late high prio overtakes", got_cyc[1], 3);
    check(got_cyc[8] == 4, "R6 R2 receiver last", got_cyc[8], 4);
  endtask

  task automatic t_raw();
    single(2, 1'b1, 100, 32'h0000_0AAA, '0, "R9 seed");
    b_addr[1] = 13'd100; b_addr[2] = 13'd100; b_addr[6] = 13'd100;
    b_we[2] = 1'b1; b_wd[2] = 32'h0000_0BBB;
    run_batch(9'b0_0100_0110, '0, 0, 8);
    b_we[2] = 1'b0;
    check(got_rd[1] == 32'h0AAA, "R9 earlier read sees old", got_rd[1], 32'h0AAA);
    check(got_cyc[2] == 3, "R9 writer order", got_cyc[2], 3);
    check(got_rd[6] == 32'h0BBB, "R9 later read sees new", got_rd[6], 32'h0BBB);
  endtask

  task automatic t_hold();
    int cnt = 0;
    b_we[5] = 1'b0; b_addr[5] = 13'd4;
    @(negedge clk);
    b_req[5] = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if (ack[5]) cnt++;
      if (c == 3) b_req[5] = 1'b0; // held through the ack cycle (c==2)
    end
    check(cnt == 1, "R8 held request served once", cnt, 1);
    check(ack == '0, "R8 no stray ack", ack, 0);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin b_addr[i] = '0; b_wd[i] = '0; end
    t_reset();
    t_single();
    t_banks();
    t_all_contend();
    t_late_overtake();
    t_raw();
    t_hold();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule